// File: doc/BRIEF.md
# Two-Group Reset Stretcher

This block collects a set of active-high reset requests and turns them into two active-low reset outputs. A parameter mask classes each request line as either cold or warm. Cold means a power-on type event, for example supply ramp-up or a fuse load failure. Warm means a lighter event, such as a software request, a watchdog expiry, an external pin or a debugger request. The cold output follows only the cold lines. The combined output follows every line.

Assertion is immediate and needs no clock. Release is synchronised to the clock through two flops and then held off by a counter. Each output group has its own programmable hold length.

A sticky status register records which lines caused a reset; a mask excludes some lines from logging. A small register port gives software access to the status and the two hold lengths.

Top module: `rst_stretch_mgr`

## Requirements
- R1: While any cold line of `src_req` is high (bits set in COLD_MASK, default bits 0 and 1), both `cold_rst_n` and `warm_rst_n` are low in the same timestep, with no clock edge needed.
- R2: A request on warm lines only drives `warm_rst_n` low and leaves `cold_rst_n` high.
- R3: Count the rising edges that follow the drop of a group's last request. The output goes high right after edge L+2, where L is the effective hold length of that group. Before that edge the output stays low.
- R4: If any line of a group asserts again while that group's output is being held, the count restarts from the new release.
- R5: After `rst`, both hold length registers read 16. Register address 1 holds the cold-group length and address 2 holds the combined-group length, in the low CNT_W bits. Reads return data one clock after the address is applied.
- R6: A programmed hold length of 0 reads back as 0 and behaves as a length of 1, so release comes after 3 edges.
- R7: Status register address 0, bit i, becomes 1 after line i has been high, provided bit i of LOG_MASK is set. Bits that LOG_MASK leaves clear (default: bit 4) always read 0. Status bits stay set after the line drops.
- R8: A write to address 0 clears every status bit whose data bit is 1 and leaves the other bits unchanged.
- R9: While any cold line is seen, the status bits of warm lines are cleared. The only exception is a warm line that is itself high at that moment.
- R10: While `rst` is high, both outputs are low. After `rst` falls, both outputs release on the R3 schedule using the default length 16, that is on the 18th rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block |
| src_req | input | N_SRC | Active-high reset requests, one per line |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| cold_rst_n | output | 1 | Active-low reset driven by cold lines |
| warm_rst_n | output | 1 | Active-low reset driven by all lines |

## Verification
Output assertion has no latency. The bench drives a request at a falling edge and checks both outputs 1 ns later. Release is due on the L+2-th rising edge after the request drops. The bench counts rising edges from that drop, samples at each following falling edge, and expects low before the due edge and high from it on. Status bits settle three edges after a request rises, because of two synchroniser flops and the status flop. The bench reads status only after the whole release window, and a read result is taken at the falling edge after the address was applied.

// File: rtl/rstmgr_pkg.sv
package rstmgr_pkg;
  localparam int ADDR_W   = 2;
  localparam int N_GROUPS = 2;
  localparam int GRP_COLD = 0;
  localparam int GRP_WARM = 1;

  typedef enum logic [ADDR_W-1:0] {
    REG_STATUS   = 2'd0,
    REG_COLD_LEN = 2'd1,
    REG_WARM_LEN = 2'd2,
    REG_SPARE    = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/rstmgr_stretch.sv
module rstmgr_stretch #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             rst_n_o
);
  logic [1:0]       sync_q;
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] len_eff;
  logic             last_tick;

  assign len_eff   = (len_i == '0) ? CNT_W'(1) : len_i;
  assign last_tick = ({1'b0, cnt_q} + 1'b1) >= {1'b0, len_q};

  // request sets the chain at once; release walks out through two flops
  always_ff @(posedge clk or posedge req_i) begin
    if (req_i)    sync_q <= 2'b11;
    else if (rst) sync_q <= 2'b11;
    else          sync_q <= {sync_q[0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      len_q  <= CNT_W'(1);
    end else if (sync_q[1]) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      len_q  <= len_eff;
    end else if (busy_q) begin
      if (last_tick) busy_q <= 1'b0;
      else           cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign rst_n_o = ~(req_i | sync_q[1] | busy_q);

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt_q < len_q));

  assert_len_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (len_q != '0));

  assert_restart_R4: assert property (@(posedge clk) disable iff (rst)
    sync_q[1] |=> (busy_q && cnt_q == '0));
endmodule

// File: rtl/rstmgr_regs.sv
module rstmgr_regs import rstmgr_pkg::*; #(
  parameter int               N_SRC     = 6,
  parameter int               CNT_W     = 8,
  parameter int               DATA_W    = 16,
  parameter int               LEN_INIT  = 16,
  parameter logic [N_SRC-1:0] COLD_MASK = 6'b000011,
  parameter logic [N_SRC-1:0] LOG_MASK  = 6'b101111
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  cold_len_o,
  output logic [CNT_W-1:0]  warm_len_o
);
  logic [N_SRC-1:0] s1_q, s2_q;
  logic [N_SRC-1:0] status_q, status_d;
  logic             cold_seen;
  logic             unused_wdata;
  reg_sel_e         sel;

  assign sel          = reg_sel_e'(addr);
  assign cold_seen    = |(s2_q & COLD_MASK);
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= src_req;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    status_d = status_q;
    if (wr && sel == REG_STATUS) status_d = status_d & ~wdata[N_SRC-1:0];
    if (cold_seen)               status_d = status_d & COLD_MASK;
    status_d = status_d | (s2_q & LOG_MASK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q   <= '0;
      cold_len_o <= CNT_W'(LEN_INIT);
      warm_len_o <= CNT_W'(LEN_INIT);
      rdata      <= '0;
    end else begin
      status_q <= status_d;
      if (wr && sel == REG_COLD_LEN) cold_len_o <= wdata[CNT_W-1:0];
      if (wr && sel == REG_WARM_LEN) warm_len_o <= wdata[CNT_W-1:0];
      case (sel)
        REG_STATUS:   rdata <= DATA_W'(status_q);
        REG_COLD_LEN: rdata <= DATA_W'(cold_len_o);
        REG_WARM_LEN: rdata <= DATA_W'(warm_len_o);
        default:      rdata <= '0;
      endcase
    end
  end

  assert_w1c_R8: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == REG_STATUS) |=>
      ((status_q & $past(wdata[N_SRC-1:0]) & ~$past(s2_q & LOG_MASK)) == '0));

  assert_cold_wipes_warm_R9: assert property (@(posedge clk) disable iff (rst)
    cold_seen |=> ((status_q & ~COLD_MASK & ~$past(s2_q)) == '0));

  assert_unlogged_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (status_q & ~LOG_MASK) == '0);
endmodule

// File: rtl/rst_stretch_mgr.sv
module rst_stretch_mgr import rstmgr_pkg::*; #(
  parameter int               N_SRC     = 6,
  parameter int               CNT_W     = 8,
  parameter int               DATA_W    = 16,
  parameter int               LEN_INIT  = 16,
  parameter logic [N_SRC-1:0] COLD_MASK = 6'b000011,
  parameter logic [N_SRC-1:0] LOG_MASK  = 6'b101111
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_req,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              cold_rst_n,
  output logic              warm_rst_n
);
  logic                cold_any;
  logic                all_any;
  logic [N_GROUPS-1:0] grp_req;
  logic [N_GROUPS-1:0] grp_rst_n;
  logic [CNT_W-1:0]    grp_len [N_GROUPS];

  assign cold_any          = |(src_req & COLD_MASK);
  assign all_any           = |src_req;
  assign grp_req[GRP_COLD] = cold_any;
  assign grp_req[GRP_WARM] = all_any;

  rstmgr_regs #(
    .N_SRC(N_SRC), .CNT_W(CNT_W), .DATA_W(DATA_W), .LEN_INIT(LEN_INIT),
    .COLD_MASK(COLD_MASK), .LOG_MASK(LOG_MASK)
  ) u_regs (
    .clk(clk), .rst(rst), .src_req(src_req),
    .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .cold_len_o(grp_len[GRP_COLD]), .warm_len_o(grp_len[GRP_WARM])
  );

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_chan
    rstmgr_stretch #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst(rst), .req_i(grp_req[g]),
      .len_i(grp_len[g]), .rst_n_o(grp_rst_n[g])
    );
  end

  assign cold_rst_n = grp_rst_n[GRP_COLD];
  assign warm_rst_n = grp_rst_n[GRP_WARM];

  assert_cold_hits_both_R1: assert property (@(posedge clk) disable iff (rst)
    cold_any |-> (!cold_rst_n && !warm_rst_n));
endmodule

// File: tb/rst_stretch_mgr_bench.sv
`timescale 1ns/1ps
module rst_stretch_mgr_bench;
  localparam int          N_SRC = 6;
  localparam int          DW    = 16;
  localparam logic [5:0]  COLD  = 6'b000011;
  localparam logic [5:0]  LOGM  = 6'b101111;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N_SRC-1:0] src_req = '0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          cold_rst_n, warm_rst_n;

  int total = 0;
  int bad   = 0;
  int cur_lc = 16, cur_lw = 16;
  logic [5:0] exp_stat = '0;

  always #2.5 clk = ~clk;

  rst_stretch_mgr u_rst_stretch_mgr (
    .clk(clk), .rst(rst), .src_req(src_req), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n)
  );

  function automatic int eff(int l);
    return (l == 0) ? 1 : l;
  endfunction

  function automatic logic [5:0] stat_after(logic [5:0] s, logic [5:0] m);
    logic [5:0] r;
    r = s;
    if ((m & COLD) != 0) r = r & COLD;
    return r | (m & LOGM);
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic reg_write(logic [1:0] a, int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = DW'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [1:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = int'(reg_rdata);
  endtask

  // raise mask for hold edges, then check both release schedules
  task automatic pulse(logic [5:0] m, int hold);
    int ec, ew, kmax;
    bit hc;
    hc = (m & COLD) != 0;
    @(negedge clk);
    src_req = m;
    #1;
    chk(hc ? "R1 cold out" : "R2 cold out", int'(cold_rst_n), hc ? 0 : 1);
    chk(hc ? "R1 warm out" : "R2 warm out", int'(warm_rst_n), 0);
    repeat (hold) @(negedge clk);
    src_req = '0;
    ec = eff(cur_lc) + 2;
    ew = eff(cur_lw) + 2;
    kmax = (hc && ec > ew) ? ec : ew;
    for (int k = 1; k <= kmax; k++) begin
      @(negedge clk);
      chk(hc ? "R3 cold release" : "R2 cold idle", int'(cold_rst_n),
          (!hc || k >= ec) ? 1 : 0);
      chk("R3 warm release", int'(warm_rst_n), (k >= ew) ? 1 : 0);
    end
    exp_stat = stat_after(exp_stat, m);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int v;
    void'($urandom(32'h0000_5eed));
    repeat (3) @(negedge clk);
    chk("R10 cold in rst", int'(cold_rst_n), 0);
    chk("R10 warm in rst", int'(warm_rst_n), 0);
    rst = 1'b0;
    for (int k = 1; k <= 18; k++) begin
      @(negedge clk);
      if (k >= 17) begin
        chk("R10 cold after rst", int'(cold_rst_n), (k >= 18) ? 1 : 0);
        chk("R10 warm after rst", int'(warm_rst_n), (k >= 18) ? 1 : 0);
      end
    end
    reg_read(2'd0, v); chk("R5 status reset", v, 0);
    reg_read(2'd1, v); chk("R5 cold len reset", v, 16);
    reg_read(2'd2, v); chk("R5 warm len reset", v, 16);

    // R6: zero length acts as one
    reg_write(2'd2, 0); cur_lw = 0;
    reg_read(2'd2, v); chk("R6 zero readback", v, 0);
    reg_write(2'd1, 3); cur_lc = 3;
    pulse(6'b001000, 2);

    // R4: restart during stretch
    reg_write(2'd2, 5); cur_lw = 5;
    @(negedge clk); src_req = 6'b100000;
    repeat (2) @(negedge clk); src_req = '0;
    repeat (4) @(negedge clk);
    chk("R4 warm still held", int'(warm_rst_n), 0);
    src_req = 6'b100000; #1;
    chk("R4 reassert low", int'(warm_rst_n), 0);
    @(negedge clk); src_req = '0;
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      if (k >= 6) chk("R4 restarted release", int'(warm_rst_n), (k >= 7) ? 1 : 0);
    end
    exp_stat = stat_after(exp_stat, 6'b100000);

    // R7 / R9: unlogged line and cold wipe
    pulse(6'b010100, 1);
    reg_read(2'd0, v); chk("R7 status log", v, int'(exp_stat));
    pulse(6'b000010, 2);
    reg_read(2'd0, v); chk("R9 cold wipe", v, int'(exp_stat));

    for (int it = 0; it < 24; it++) begin
      logic [5:0] m, clr;
      if (it % 3 == 0) begin
        cur_lc = $urandom_range(0, 7); reg_write(2'd1, cur_lc);
        cur_lw = $urandom_range(0, 7); reg_write(2'd2, cur_lw);
      end
      m = 6'($urandom_range(1, 63));
      pulse(m, $urandom_range(1, 4));
      if (it % 4 == 3) begin
        reg_read(2'd0, v); chk("R7 R9 status", v, int'(exp_stat));
        clr = 6'($urandom_range(0, 63));
        reg_write(2'd0, int'(clr));
        exp_stat = exp_stat & ~clr;
        reg_read(2'd0, v); chk("R8 w1c", v, int'(exp_stat));
      end
    end
    reg_write(2'd0, 63); exp_stat = '0;
    reg_read(2'd0, v); chk("R8 clear all", v, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule